// File: doc/BRIEF.md
# Shadow Metadata Address Translation Cache

This block is a small fully associative table that converts an application data address into the address of the shadow metadata describing it. A monitoring handler presents an application address. If the upper half of the address matches a stored tag, the block returns the metadata address in the same cycle. That address is the stored chunk base plus a scaled offset taken from the lower half of the address. It replaces the several-instruction index lookup and offset arithmetic that handler software would otherwise run for every checked access.

A miss raises a flag so that user-mode monitoring software can find the chunk itself and install it. The software fills entries through a fill port and can drop the whole table at once with a global invalidate. Two configuration inputs fit the offset arithmetic to each monitor. One is a right-shift that sets how many application bytes share one metadata element. The other is the log2 of the element size in bytes.

Top module: `shadow_xlate_cache`

## Requirements
- R1: When `lk_valid` is 1 and the tag matches a valid entry, `lk_hit`=1 and `lk_meta_addr` = base + ((lk_addr[15:0] >> cfg_gran_shift) * 2^cfg_elem_log2), truncated to 32 bits. The result is combinational and appears in the same cycle.
- R2: When `lk_valid` is 1 and no valid entry matches, `lk_miss`=1, `lk_hit`=0 and `lk_meta_addr`=0. When `lk_valid` is 0, all three outputs are 0.
- R3: The tag is lk_addr[31:16] and only those bits select the entry. lk_addr[15:0] affects only the offset.
- R4: `cfg_gran_shift` (0..7) is the right-shift applied to the low 16 address bits before scaling.
- R5: `cfg_elem_log2` (0..3) scales the element index by 1, 2, 4 or 8 bytes.
- R6: A fill whose tag is not present writes the entry at a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping after entry 7. After eight such fills, a ninth replaces the oldest entry.
- R7: A fill whose tag is already present overwrites that entry's base. It creates no second copy and does not advance the pointer.
- R8: `inv_all` clears every entry in one cycle and returns the pointer to 0. A fill in the same cycle is ignored.
- R9: After reset, every lookup misses.
- R10: A fill takes effect at the next clock edge. A lookup in the fill cycle sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_gran_shift | input | 3 | Right-shift applied to the low address half |
| cfg_elem_log2 | input | 2 | Log2 of the metadata element size in bytes |
| lk_valid | input | 1 | Lookup request present |
| lk_addr | input | 32 | Application address to translate |
| lk_hit | output | 1 | Lookup found a matching entry |
| lk_miss | output | 1 | Lookup found no entry (software fill needed) |
| lk_meta_addr | output | 32 | Metadata address, 0 unless hit |
| fill_en | input | 1 | Install or refresh an entry |
| fill_tag | input | 16 | Upper address half for the entry |
| fill_base | input | 32 | Chunk base address for the entry |
| inv_all | input | 1 | Clear all entries |

## Verification
The assertions check on every cycle that hit and miss exclude each other and follow the request, and that a miss drives a zero address. They also check that at most one entry ever matches, that a fill is visible on the next cycle, that an invalidate empties the table, and how the replacement pointer moves for new and repeated tags. Only the bench scenarios can show that the returned address is numerically right for each shift and element size, that the ninth distinct fill evicts the first entry, and that a fill arriving together with an invalidate leaves nothing behind. These are checked against a behavioural model on every clock.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int GRAN_W = 3;
  localparam int ESZ_W  = 2;

  typedef struct packed {
    logic [GRAN_W-1:0] gran;
    logic [ESZ_W-1:0]  esz;
  } smc_cfg_t;
endpackage

// File: rtl/smc_tag_store.sv
module smc_tag_store #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 16,
  parameter int META_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear_all,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [TAG_W-1:0]    wr_tag,
  input  logic [META_W-1:0]   wr_base,
  input  logic [TAG_W-1:0]    lk_tag,
  output logic [ENTRIES-1:0]  lk_match,
  output logic [META_W-1:0]   lk_base,
  input  logic [TAG_W-1:0]    probe_tag,
  output logic                probe_hit,
  output logic [IDX_W-1:0]    probe_idx
);
  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [META_W-1:0]  base_q [ENTRIES];
  logic [ENTRIES-1:0] probe_match;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[i]  <= 1'b0;
        tag_q[i]  <= '0;
        base_q[i] <= '0;
      end else if (clear_all) begin
        vld_q[i] <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(i)) begin
        vld_q[i]  <= 1'b1;
        tag_q[i]  <= wr_tag;
        base_q[i] <= wr_base;
      end
    end
    assign lk_match[i]    = vld_q[i] && (tag_q[i] == lk_tag);
    assign probe_match[i] = vld_q[i] && (tag_q[i] == probe_tag);
  end

  // match vectors are at most one-hot, so an OR of masked bases is a mux
  always_comb begin
    lk_base = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) lk_base = lk_base | base_q[i];
    end
  end

  always_comb begin
    probe_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (probe_match[i]) probe_idx = probe_idx | IDX_W'(i);
    end
  end

  assign probe_hit = |probe_match;
endmodule

// File: rtl/smc_rr_victim.sv
module smc_rr_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  function automatic logic [IDX_W-1:0] next_ptr(input logic [IDX_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (restart) ptr <= '0;
    else if (step)    ptr <= next_ptr(ptr);
  end
endmodule

// File: rtl/smc_meta_addr_gen.sv
module smc_meta_addr_gen
  import smc_pkg::*;
#(
  parameter int OFF_W  = 16,
  parameter int META_W = 32
) (
  input  logic [META_W-1:0] base,
  input  logic [OFF_W-1:0]  low,
  input  smc_cfg_t          cfg,
  input  logic              hit,
  output logic [META_W-1:0] meta_addr
);
  function automatic logic [META_W-1:0] chunk_offset(
    input logic [OFF_W-1:0]  lo,
    input logic [GRAN_W-1:0] g,
    input logic [ESZ_W-1:0]  e
  );
    logic [META_W-1:0] wide;
    wide = META_W'(lo);
    return (wide >> g) << e;
  endfunction

  assign meta_addr = hit ? (base + chunk_offset(low, cfg.gran, cfg.esz)) : '0;
endmodule

// File: rtl/shadow_xlate_cache.sv
module shadow_xlate_cache
  import smc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int TAG_W   = 16,
  parameter int META_W  = 32,
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_gran_shift,
  input  logic [1:0]        cfg_elem_log2,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [META_W-1:0] lk_meta_addr,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [META_W-1:0] fill_base,
  input  logic              inv_all
);
  localparam int OFF_W = ADDR_W - TAG_W;
  localparam int IDX_W = $clog2(ENTRIES);

  // named internal events, observed by the bound checker
  logic [ENTRIES-1:0] hit_vec;
  logic [META_W-1:0]  hit_base;
  logic               fill_go;
  logic               fill_known;
  logic [IDX_W-1:0]   known_idx;
  logic               fill_alloc;
  logic [IDX_W-1:0]   victim;
  logic [IDX_W-1:0]   wr_idx;
  smc_cfg_t           cfg;

  assign cfg.gran = cfg_gran_shift;
  assign cfg.esz  = cfg_elem_log2;

  assign fill_go    = fill_en && !inv_all;
  assign fill_alloc = fill_go && !fill_known;
  assign wr_idx     = fill_known ? known_idx : victim;

  smc_tag_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .META_W(META_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_all(inv_all),
    .wr_en    (fill_go),
    .wr_idx   (wr_idx),
    .wr_tag   (fill_tag),
    .wr_base  (fill_base),
    .lk_tag   (lk_addr[ADDR_W-1 -: TAG_W]),
    .lk_match (hit_vec),
    .lk_base  (hit_base),
    .probe_tag(fill_tag),
    .probe_hit(fill_known),
    .probe_idx(known_idx)
  );

  smc_rr_victim #(.ENTRIES(ENTRIES)) u_rr (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(inv_all),
    .step   (fill_alloc),
    .ptr    (victim)
  );

  assign lk_hit  = lk_valid && (|hit_vec);
  assign lk_miss = lk_valid && !(|hit_vec);

  smc_meta_addr_gen #(.OFF_W(OFF_W), .META_W(META_W)) u_agen (
    .base     (hit_base),
    .low      (lk_addr[OFF_W-1:0]),
    .cfg      (cfg),
    .hit      (lk_hit),
    .meta_addr(lk_meta_addr)
  );
endmodule

// File: rtl/shadow_xlate_cache_chk.sv
module shadow_xlate_cache_chk #(
  parameter int ADDR_W  = 32,
  parameter int TAG_W   = 16,
  parameter int META_W  = 32,
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              lk_hit,
  input logic              lk_miss,
  input logic [META_W-1:0] lk_meta_addr,
  input logic              fill_en,
  input logic [TAG_W-1:0]  fill_tag,
  input logic              inv_all,
  input logic [ENTRIES-1:0] hit_vec,
  input logic              fill_alloc,
  input logic              fill_known,
  input logic [IDX_W-1:0]  victim
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R2: a miss never carries an address
  assert_miss_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (lk_meta_addr == '0 && !lk_hit));

  // R2: exactly one of hit/miss answers a request, neither without one
  assert_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit || lk_miss) == lk_valid);

  // R7: a tag never lives in two entries
  assert_single_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R10: a fill is found by a lookup on the next cycle
  assert_fill_visible_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(fill_en && !inv_all) && lk_valid &&
     lk_addr[ADDR_W-1 -: TAG_W] == $past(fill_tag)) |-> lk_hit);

  // R8: invalidate empties the table
  assert_inv_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(inv_all)) |-> (hit_vec == '0));

  // R6: allocating fill moves the pointer by one, wrapping
  assert_rr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(fill_alloc)) |->
      (victim == (($past(victim) == LAST) ? '0 : $past(victim) + 1'b1)));

  // R7: refreshing a known tag leaves the pointer alone
  assert_rr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(fill_en && !inv_all && fill_known)) |-> $stable(victim));
endmodule

bind shadow_xlate_cache shadow_xlate_cache_chk #(
  .ADDR_W(ADDR_W), .TAG_W(TAG_W), .META_W(META_W), .ENTRIES(ENTRIES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lk_valid    (lk_valid),
  .lk_addr     (lk_addr),
  .lk_hit      (lk_hit),
  .lk_miss     (lk_miss),
  .lk_meta_addr(lk_meta_addr),
  .fill_en     (fill_en),
  .fill_tag    (fill_tag),
  .inv_all     (inv_all),
  .hit_vec     (hit_vec),
  .fill_alloc  (fill_alloc),
  .fill_known  (fill_known),
  .victim      (victim)
);

// File: tb/shadow_xlate_cache_tb.sv
module shadow_xlate_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_gran_shift = '0;
  logic [1:0]  cfg_elem_log2 = '0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        lk_hit, lk_miss;
  logic [31:0] lk_meta_addr;
  logic        fill_en = 1'b0;
  logic [15:0] fill_tag = '0;
  logic [31:0] fill_base = '0;
  logic        inv_all = 1'b0;

  int checks = 0;
  int bad = 0;

  // behavioural model: list of (tag, base) pairs in slot order plus a slot counter
  int          m_slot_tag  [8];
  longint      m_slot_base [8];
  bit          m_slot_used [8];
  int          m_next = 0;

  always #5 clk = ~clk;

  shadow_xlate_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_gran_shift(cfg_gran_shift), .cfg_elem_log2(cfg_elem_log2),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_meta_addr(lk_meta_addr),
    .fill_en(fill_en), .fill_tag(fill_tag), .fill_base(fill_base),
    .inv_all(inv_all)
  );

  task automatic model_clear();
    for (int i = 0; i < 8; i++) begin
      m_slot_used[i] = 0;
      m_slot_tag[i]  = 0;
      m_slot_base[i] = 0;
    end
    m_next = 0;
  endtask

  task automatic model_update();
    int where;
    if (inv_all) begin
      model_clear();
      return;
    end
    if (!fill_en) return;
    where = -1;
    for (int i = 0; i < 8; i++)
      if (m_slot_used[i] && m_slot_tag[i] == int'(fill_tag)) where = i;
    if (where < 0) begin
      where = m_next;
      m_next = (m_next + 1) % 8;
    end
    m_slot_used[where] = 1;
    m_slot_tag[where]  = int'(fill_tag);
    m_slot_base[where] = longint'(fill_base);
  endtask

  task automatic compare(input string req);
    bit     e_hit, e_miss;
    longint e_addr;
    int     found;
    found = -1;
    for (int i = 0; i < 8; i++)
      if (m_slot_used[i] && m_slot_tag[i] == int'(lk_addr[31:16])) found = i;
    e_hit  = lk_valid && found >= 0;
    e_miss = lk_valid && found < 0;
    e_addr = 0;
    if (e_hit)
      e_addr = (m_slot_base[found] +
                (longint'(lk_addr[15:0]) / (longint'(1) << cfg_gran_shift)) *
                (longint'(1) << cfg_elem_log2)) % (longint'(1) << 32);
    checks++;
    if (lk_hit !== e_hit || lk_miss !== e_miss || longint'(lk_meta_addr) != e_addr) begin
      bad++;
      $display("FAIL %s: hit=%0b miss=%0b addr=%h expected hit=%0b miss=%0b addr=%h",
               req, lk_hit, lk_miss, lk_meta_addr, e_hit, e_miss, e_addr[31:0]);
    end
  endtask

  // one clock: drive at posedge+1, compare mid-cycle, model follows the edge
  task automatic cyc(input bit lv, input logic [31:0] a, input bit fe,
                     input logic [15:0] ft, input logic [31:0] fb, input bit inv,
                     input string req);
    lk_valid = lv; lk_addr = a; fill_en = fe; fill_tag = ft; fill_base = fb; inv_all = inv;
    #3;
    compare(req);
    @(posedge clk);
    model_update();
    #1;
  endtask

  task automatic look(input logic [31:0] a, input string req);
    cyc(1'b1, a, 1'b0, '0, '0, 1'b0, req);
  endtask

  task automatic fill(input logic [15:0] t, input logic [31:0] b, input string req);
    cyc(1'b0, '0, 1'b1, t, b, 1'b0, req);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    model_clear();
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;

    // R9 / R2: empty table, idle and requested lookups
    cyc(1'b0, 32'h1234_0010, 1'b0, '0, '0, 1'b0, "R2 idle");
    look(32'h1234_0010, "R9 miss after reset");

    // R10: fill and lookup together see old contents, then hit
    cfg_gran_shift = 3'd2; cfg_elem_log2 = 2'd0;
    cyc(1'b1, 32'h1234_0010, 1'b1, 16'h1234, 32'h8000_0000, 1'b0, "R10 same-cycle miss");
    look(32'h1234_0010, "R1 R10 hit next cycle");

    // R3: other upper half misses, low bits only move the offset
    look(32'h1235_0010, "R3 other tag");
    look(32'h1234_FFFC, "R3 low bits offset");

    // R4 / R5: configuration sweep
    for (int g = 0; g < 8; g++) begin
      for (int e = 0; e < 4; e++) begin
        cfg_gran_shift = 3'(g); cfg_elem_log2 = 2'(e);
        look(32'h1234_ABCD, "R4 R5 scaling");
      end
    end

    // R1: 32-bit wrap of the sum
    cfg_gran_shift = 3'd0; cfg_elem_log2 = 2'd3;
    fill(16'h0042, 32'hFFFF_FF00, "R1 fill near top");
    look(32'h0042_FFFF, "R1 wraparound");

    // R7: refresh of a known tag, pointer must not move
    fill(16'h1234, 32'h9000_0000, "R7 refresh");
    look(32'h1234_0008, "R7 new base");

    // R6: fill remaining slots, then the next fill evicts the oldest (0x1234)
    for (int t = 1; t <= 6; t++) fill(16'h0100 + 16'(t), 32'h4000_0000 + 32'(t) * 32'h1_0000, "R6 fill");
    look(32'h1234_0008, "R6 full table oldest present");
    look(32'h0106_0020, "R6 full table newest present");
    fill(16'h0777, 32'h7000_0000, "R6 evict");
    look(32'h1234_0008, "R6 oldest evicted");
    look(32'h0042_0000, "R6 second survives");
    look(32'h0777_0010, "R6 new entry");
    fill(16'h0888, 32'h7100_0000, "R6 evict second");
    look(32'h0042_0000, "R6 second evicted");

    // R8: invalidate with simultaneous fill
    cyc(1'b1, 32'h0777_0010, 1'b1, 16'h0999, 32'h1111_0000, 1'b1, "R8 inv cycle");
    look(32'h0777_0010, "R8 cleared");
    look(32'h0999_0000, "R8 fill ignored");
    fill(16'h0AAA, 32'h2000_0000, "R8 refill");
    look(32'h0AAA_0040, "R8 R6 pointer back at start");
    for (int t = 0; t < 8; t++) fill(16'h0B00 + 16'(t), 32'h3000_0000 + 32'(t), "R6 wrap fill");
    look(32'h0AAA_0040, "R6 wrap evicts slot zero");
    look(32'h0B07_0004, "R6 wrap last");

    cyc(1'b0, '0, 1'b0, '0, '0, 1'b0, "R2 idle end");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule